// File: doc/BRIEF.md
# JTAG Two-Device Chain ID Reader

This block is a host-side scan master. It generates the scan clock, mode-select and serial data lines for a JTAG chain of two devices. It also samples the chain's serial output, and it recovers the 32-bit identification word of the device nearest the output. In the chain, the device on the input side has a 5-bit instruction register and the device on the output side has a 4-bit one. A one-cycle `start_i` pulse launches a fixed 59-clock-period script. The script forces both state machines to Test-Logic-Reset and walks them to Shift-IR. It then shifts in a combined 9-bit instruction that puts the input-side device in BYPASS and the output-side device in IDCODE. The script returns to Run-Test/Idle, shifts 33 data bits, and returns to Run-Test/Idle.

Because the upstream device is in BYPASS, its data path is a single bit. This is why 33 data clocks are enough rather than 64. While the instruction bits are shifted, the block collects the pattern captured by both instruction registers. It uses this pattern to check the chain. A good pattern ends the run with `done_o` set and the ID on `id_o`. A bad pattern ends it with `fail_o` set instead. The `HALF_DIV` parameter sets how many system clocks each scan-clock phase lasts.

Top module: `jtag_id_reader`

## Requirements
- R1: After reset `scan_clk_o`=0, `scan_mode_o`=1, `scan_di_o`=0, and `busy_o`, `done_o` and `fail_o` are all 0.
- R2: A `start_i` pulse while idle sets `busy_o` and produces exactly 59 scan-clock rising edges. Each high phase and each low phase lasts `HALF_DIV` system clocks. `busy_o` clears on the system clock that ends the final low-going edge, and the scan clock rests low while idle.
- R3: The mode-select values seen at the 59 rising edges, in order, are: five 1s; then 0,1,1,0,0; then eight 0s followed by a 1; then 1,0; then 1,0,0; then thirty-two 0s followed by a 1; then 1,0.
- R4: At rising edges 11 to 19 (1-based), serial data out carries the 9-bit instruction LSB first. The instruction is {5'b11111 (BYPASS, input-side device), 4'b1110 (IDCODE, output-side device)}, giving the stream 0,1,1,1,1,1,1,1,1. At every other rising edge, serial data out is 0.
- R5: Mode-select and serial data out change only while the scan clock is low: at a falling edge, or at launch.
- R6: Serial input is sampled at rising edges 25 to 56. The first sampled bit lands in `id_o[0]` and the 32nd in `id_o[31]`. The 33rd data bit, which is the bypass bit, is discarded.
- R7: The 9 serial-input bits sampled at rising edges 11 to 19 must equal the stream 1,0,0,0,1,0,0,0,0, which is the 4-bit capture 4'b0001 followed by the 5-bit capture 5'b00001. If they do not, the run ends with `fail_o`=1 and `done_o`=0. If they do, it ends with `done_o`=1 and `fail_o`=0.
- R8: `done_o`, `fail_o` and `id_o` hold their values after a run until the next accepted start. Both flags clear on the clock that accepts that start.
- R9: A `start_i` pulse while `busy_o`=1 is ignored. The run in progress completes with its normal 59 edges and result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle launch request |
| scan_do_i | input | 1 | Serial data returned from the chain |
| scan_clk_o | output | 1 | Generated scan clock |
| scan_mode_o | output | 1 | Mode-select line to the chain |
| scan_di_o | output | 1 | Serial data driven into the chain |
| busy_o | output | 1 | Script in progress |
| done_o | output | 1 | Last run succeeded, `id_o` valid |
| fail_o | output | 1 | Last run saw a bad instruction capture pattern |
| id_o | output | 32 | Recovered identification word |

## Verification
The assertions assume that the chain changes its serial output only on a falling scan-clock edge. They also assume that this output stays stable for `HALF_DIV` system clocks before each rising edge. For this reason the RTL samples it without a synchronizer. The bench keeps to this assumption with a behavioural two-device model. The model updates its output on the falling scan-clock edge and starts in an arbitrary state, Shift-DR. The bench sends `start_i` only on falling system-clock edges. It delivers one extra pulse mid-run to exercise the ignore rule.

// File: rtl/jtag_id_reader_pkg.sv
package jtag_id_reader_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } phase_e;

  // Number of scan-clock periods in the whole script
  function automatic int script_len(input int reset_cyc, input int ir_w, input int id_w);
    return reset_cyc + 5 + ir_w + 2 + 3 + id_w + 1 + 2;
  endfunction

endpackage

// File: rtl/jtag_id_steps.sv
// Maps a script step index to the line values driven during that step and
// to the sample windows for the serial input at its rising edge.
module jtag_id_steps #(
  parameter int RESET_CYC = 5,
  parameter int IR_W      = 9,
  parameter int ID_W      = 32,
  parameter int SW        = 6,
  parameter logic [IR_W-1:0] IR_IN = '1
) (
  input  logic [SW-1:0] idx_i,
  output logic          mode_o,
  output logic          din_o,
  output logic          ir_win_o,
  output logic          dr_win_o
);
  localparam int S_TOIR = RESET_CYC;
  localparam int S_IR   = S_TOIR + 5;
  localparam int S_IRX  = S_IR + IR_W;
  localparam int S_TODR = S_IRX + 2;
  localparam int S_DR   = S_TODR + 3;
  localparam int S_DRX  = S_DR + ID_W + 1;

  always_comb begin
    int i;
    logic [IR_W-1:0] sh;
    i        = int'(idx_i);
    sh       = '0;
    mode_o   = 1'b0;
    din_o    = 1'b0;
    ir_win_o = 1'b0;
    dr_win_o = 1'b0;
    if (i < S_TOIR) begin
      mode_o = 1'b1;                                   // force reset
    end else if (i < S_IR) begin
      mode_o = (i == S_TOIR + 1) || (i == S_TOIR + 2); // 0,1,1,0,0
    end else if (i < S_IRX) begin
      ir_win_o = 1'b1;
      mode_o   = (i == S_IRX - 1);
      sh       = IR_IN >> (i - S_IR);
      din_o    = sh[0];
    end else if (i < S_TODR) begin
      mode_o = (i == S_IRX);                           // 1,0
    end else if (i < S_DR) begin
      mode_o = (i == S_TODR);                          // 1,0,0
    end else if (i < S_DRX) begin
      dr_win_o = (i < S_DR + ID_W);                    // last bit is bypass
      mode_o   = (i == S_DRX - 1);
    end else begin
      mode_o = (i == S_DRX);                           // 1,0
    end
  end
endmodule

// File: rtl/jtag_id_tick.sv
// Phase timer: pulses once every HALF_DIV system clocks while running.
module jtag_id_tick #(
  parameter int HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  output logic tick_o
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] CMAX = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt;

  assign tick_o = run_i && (cnt == CMAX);

  always_ff @(posedge clk) begin
    if (rst || !run_i || tick_o) cnt <= '0;
    else                         cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/jtag_id_capture.sv
// Collects sampled serial-input bits, first bit ending in bit 0.
module jtag_id_capture #(
  parameter int IR_W = 9,
  parameter int ID_W = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr_i,
  input  logic            smp_ir_i,
  input  logic            smp_dr_i,
  input  logic            bit_i,
  output logic [IR_W-1:0] ir_cap_o,
  output logic [ID_W-1:0] id_word_o
);
  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      ir_cap_o  <= '0;
      id_word_o <= '0;
    end else begin
      if (smp_ir_i) ir_cap_o  <= {bit_i, ir_cap_o[IR_W-1:1]};
      if (smp_dr_i) id_word_o <= {bit_i, id_word_o[ID_W-1:1]};
    end
  end

  // R6/R7: the two sample windows never overlap
  p_one_window_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot0({smp_ir_i, smp_dr_i}));
endmodule

// File: rtl/jtag_id_reader.sv
module jtag_id_reader #(
  parameter int HALF_DIV  = 4,
  parameter int RESET_CYC = 5,
  parameter int UP_IR_W   = 5,
  parameter int DN_IR_W   = 4,
  parameter int ID_W      = 32,
  parameter logic [DN_IR_W-1:0] DN_ID_INS  = 4'b1110,
  parameter logic [UP_IR_W-1:0] UP_BYP_INS = '1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start_i,
  input  logic            scan_do_i,
  output logic            scan_clk_o,
  output logic            scan_mode_o,
  output logic            scan_di_o,
  output logic            busy_o,
  output logic            done_o,
  output logic            fail_o,
  output logic [ID_W-1:0] id_o
);
  import jtag_id_reader_pkg::*;

  localparam int IR_W    = UP_IR_W + DN_IR_W;
  localparam int N_STEPS = script_len(RESET_CYC, IR_W, ID_W);
  localparam int SW      = $clog2(N_STEPS + 1);
  localparam logic [SW-1:0] LAST = SW'(N_STEPS - 1);
  localparam logic [IR_W-1:0] IR_IN   = {UP_BYP_INS, DN_ID_INS};
  // Each register captures ...01; the output-side one leaves first
  localparam logic [IR_W-1:0] CAP_EXP =
    {{(UP_IR_W-1){1'b0}}, 1'b1, {(DN_IR_W-1){1'b0}}, 1'b1};

  phase_e          ph;
  logic [SW-1:0]   step;
  logic [SW-1:0]   load_idx;
  logic            tick;
  logic            s_mode, s_din, s_irw, s_drw;
  logic            win_ir, win_dr;
  logic            smp_ir, smp_dr, clr;
  logic [IR_W-1:0] ir_cap;
  logic [ID_W-1:0] id_word;
  logic            launch;

  assign launch   = (ph == PH_IDLE) && start_i;
  assign load_idx = (ph == PH_IDLE) ? '0 : step + 1'b1;
  assign smp_ir   = (ph == PH_LOW) && tick && win_ir;
  assign smp_dr   = (ph == PH_LOW) && tick && win_dr;
  assign clr      = launch;
  assign busy_o   = (ph != PH_IDLE);

  jtag_id_tick #(.HALF_DIV(HALF_DIV)) u_tick (
    .clk(clk), .rst(rst), .run_i(busy_o), .tick_o(tick)
  );

  jtag_id_steps #(
    .RESET_CYC(RESET_CYC), .IR_W(IR_W), .ID_W(ID_W), .SW(SW), .IR_IN(IR_IN)
  ) u_steps (
    .idx_i(load_idx), .mode_o(s_mode), .din_o(s_din),
    .ir_win_o(s_irw), .dr_win_o(s_drw)
  );

  jtag_id_capture #(.IR_W(IR_W), .ID_W(ID_W)) u_cap (
    .clk(clk), .rst(rst), .clr_i(clr), .smp_ir_i(smp_ir), .smp_dr_i(smp_dr),
    .bit_i(scan_do_i), .ir_cap_o(ir_cap), .id_word_o(id_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ph          <= PH_IDLE;
      step        <= '0;
      scan_clk_o  <= 1'b0;
      scan_mode_o <= 1'b1;
      scan_di_o   <= 1'b0;
      win_ir      <= 1'b0;
      win_dr      <= 1'b0;
      done_o      <= 1'b0;
      fail_o      <= 1'b0;
      id_o        <= '0;
    end else begin
      case (ph)
        PH_IDLE: if (start_i) begin
          ph          <= PH_LOW;
          step        <= '0;
          scan_mode_o <= s_mode;
          scan_di_o   <= s_din;
          win_ir      <= s_irw;
          win_dr      <= s_drw;
          done_o      <= 1'b0;
          fail_o      <= 1'b0;
        end
        PH_LOW: if (tick) begin
          scan_clk_o <= 1'b1;
          ph         <= PH_HIGH;
        end
        PH_HIGH: if (tick) begin
          scan_clk_o <= 1'b0;
          if (step == LAST) begin
            ph     <= PH_IDLE;
            done_o <= (ir_cap == CAP_EXP);
            fail_o <= (ir_cap != CAP_EXP);
            id_o   <= id_word;
          end else begin
            ph          <= PH_LOW;
            step        <= load_idx;
            scan_mode_o <= s_mode;
            scan_di_o   <= s_din;
            win_ir      <= s_irw;
            win_dr      <= s_drw;
          end
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end

  // R2: scan clock rests low whenever no script runs
  p_clk_low_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> !scan_clk_o);

  // R5: lines are frozen while the scan clock is (or goes) high
  p_stable_high_r5: assert property (@(posedge clk) disable iff (rst)
    scan_clk_o |-> ($stable(scan_mode_o) && $stable(scan_di_o)));

  // R7: success and failure are exclusive
  p_flags_excl_r7: assert property (@(posedge clk) disable iff (rst)
    !(done_o && fail_o));

  // R8: a result flag only appears as the script ends
  p_flag_at_end_r8: assert property (@(posedge clk) disable iff (rst)
    ($rose(done_o) || $rose(fail_o)) |-> $fell(busy_o));

  // R9: a start while running does not end or restart the run
  p_start_busy_r9: assert property (@(posedge clk) disable iff (rst)
    (busy_o && start_i && !tick) |=> (busy_o && $stable(step)));
endmodule

// File: tb/jtag_id_reader_tb.sv
module jtag_id_reader_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 3;
  localparam int NRISE      = 59;
  localparam logic [31:0] UP_ID = 32'h1357_9BDF;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic sdo;
  logic sclk, smode, sdi, busy, done, fail;
  logic [31:0] id;

  int total = 0;
  int failed = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  jtag_id_reader #(.HALF_DIV(HALF)) u_dut (
    .clk(clk), .rst(rst), .start_i(start), .scan_do_i(sdo),
    .scan_clk_o(sclk), .scan_mode_o(smode), .scan_di_o(sdi),
    .busy_o(busy), .done_o(done), .fail_o(fail), .id_o(id)
  );

  // ---------------- behavioural two-device chain ----------------
  localparam int TLR=0, RTI=1, SELDR=2, CAPDR=3, SHDR=4, EX1DR=5, PADR=6, EX2DR=7,
                 UPDR=8, SELIR=9, CAPIR=10, SHIR=11, EX1IR=12, PAIR=13, EX2IR=14, UPIR=15;

  function automatic int nxt(input int s, input logic m);
    case (s)
      TLR:   return m ? TLR   : RTI;
      RTI:   return m ? SELDR : RTI;
      SELDR: return m ? SELIR : CAPDR;
      CAPDR: return m ? EX1DR : SHDR;
      SHDR:  return m ? EX1DR : SHDR;
      EX1DR: return m ? UPDR  : PADR;
      PADR:  return m ? EX2DR : PADR;
      EX2DR: return m ? UPDR  : SHDR;
      UPDR:  return m ? SELDR : RTI;
      SELIR: return m ? TLR   : CAPIR;
      CAPIR: return m ? EX1IR : SHIR;
      SHIR:  return m ? EX1IR : SHIR;
      EX1IR: return m ? UPIR  : PAIR;
      PAIR:  return m ? EX2IR : PAIR;
      EX2IR: return m ? UPIR  : SHIR;
      default: return m ? SELDR : RTI;
    endcase
  endfunction

  int          st = SHDR;
  logic [31:0] dn_id_val = 32'h0;
  bit          corrupt = 1'b0;
  logic [3:0]  dn_ir = 4'b1110, dn_ir_sr = 4'b0;
  logic [4:0]  up_ir = 5'b00001, up_ir_sr = 5'b0;
  logic [31:0] dn_dr = 32'h0, up_dr = 32'h0;
  logic        dn_byp = 1'b0, up_byp = 1'b0;
  logic        up_out, dn_out;
  logic        tdo_m = 1'b0;

  assign up_out = (up_ir == 5'b11111) ? up_byp : up_dr[0];
  assign dn_out = (dn_ir == 4'b1110) ? dn_dr[0] : dn_byp;
  assign sdo    = tdo_m;

  always @(posedge sclk) begin
    case (st)
      TLR:   begin dn_ir <= 4'b1110; up_ir <= 5'b00001; end
      CAPIR: begin dn_ir_sr <= corrupt ? 4'b0011 : 4'b0001; up_ir_sr <= 5'b00001; end
      SHIR:  begin dn_ir_sr <= {up_ir_sr[0], dn_ir_sr[3:1]}; up_ir_sr <= {sdi, up_ir_sr[4:1]}; end
      UPIR:  begin dn_ir <= dn_ir_sr; up_ir <= up_ir_sr; end
      CAPDR: begin dn_dr <= dn_id_val; dn_byp <= 1'b0; up_dr <= UP_ID; up_byp <= 1'b0; end
      SHDR:  begin
        up_byp <= sdi;    up_dr <= {sdi, up_dr[31:1]};
        dn_byp <= up_out; dn_dr <= {up_out, dn_dr[31:1]};
      end
      default: ;
    endcase
    st <= nxt(st, smode);
  end

  always @(negedge sclk)
    tdo_m <= (st == SHIR) ? dn_ir_sr[0] : (st == SHDR) ? dn_out : 1'b0;

  // ---------------- monitors ----------------
  int   rise_cnt = 0;
  logic mode_log [64];
  logic din_log  [64];
  always @(posedge sclk) begin
    if (rise_cnt < 64) begin
      mode_log[rise_cnt] = smode;
      din_log[rise_cnt]  = sdi;
    end
    rise_cnt++;
  end

  int   hcnt = 0, half_bad = 0, edge_bad = 0;
  logic busy_q = 1'b0, sclk_q = 1'b0, mode_q = 1'b1, din_q = 1'b0;
  always @(negedge clk) begin
    if (!rst) begin
      if (busy && !busy_q) hcnt = 0; else hcnt++;
      if (sclk != sclk_q) begin
        if (hcnt != HALF) half_bad++;
        hcnt = 0;
      end
      if ((smode != mode_q || sdi != din_q) && sclk) edge_bad++;
    end
    busy_q = busy; sclk_q = sclk; mode_q = smode; din_q = sdi;
  end

  // ---------------- expected script ----------------
  function automatic logic exp_mode(input int k);
    if (k < 5)  return 1'b1;
    if (k < 10) return (k == 6 || k == 7);
    if (k < 19) return (k == 18);
    if (k < 21) return (k == 19);
    if (k < 24) return (k == 21);
    if (k < 57) return (k == 56);
    return (k == 57);
  endfunction

  function automatic logic exp_din(input int k);
    return (k >= 11 && k <= 18);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // Launch a run, optionally with a second start mid-run, and check it
  task automatic run_read(input logic [31:0] idv, input bit bad, input bit extra,
                          input string tag);
    int guard;
    int mm_mode, mm_din;
    dn_id_val = idv;
    corrupt   = bad;
    rise_cnt  = 0;
    half_bad  = 0;
    edge_bad  = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk(busy == 1'b1 && done == 1'b0 && fail == 1'b0, "R8",
        {tag, " flags clear on launch"}, {busy, done, fail}, 3'b100);
    if (extra) begin
      repeat (100) @(negedge clk);
      start = 1'b1;
      @(negedge clk) start = 1'b0;
    end
    guard = 0;
    while (busy && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    chk(guard < 2000, "R2", {tag, " run ends"}, guard, 0);
    chk(rise_cnt == NRISE, extra ? "R9" : "R2", {tag, " rising edges"}, rise_cnt, NRISE);
    chk(half_bad == 0, "R2", {tag, " phase length"}, half_bad, 0);
    chk(edge_bad == 0, "R5", {tag, " line change while high"}, edge_bad, 0);
    mm_mode = 0; mm_din = 0;
    for (int k = 0; k < NRISE; k++) begin
      if (mode_log[k] !== exp_mode(k)) mm_mode++;
      if (din_log[k]  !== exp_din(k))  mm_din++;
    end
    chk(mm_mode == 0, "R3", {tag, " mode-select script mismatches"}, mm_mode, 0);
    chk(mm_din == 0, "R4", {tag, " instruction stream mismatches"}, mm_din, 0);
    if (bad) begin
      chk(fail == 1'b1 && done == 1'b0, "R7", {tag, " bad capture flags"},
          {done, fail}, 2'b01);
    end else begin
      chk(done == 1'b1 && fail == 1'b0, "R7", {tag, " good capture flags"},
          {done, fail}, 2'b10);
      chk(id == idv, "R6", {tag, " id word"}, id, idv);
    end
  endtask

  task automatic t_reset();
    chk(sclk == 1'b0, "R1", "reset scan clock", sclk, 0);
    chk(smode == 1'b1, "R1", "reset mode-select", smode, 1);
    chk(sdi == 1'b0, "R1", "reset data out", sdi, 0);
    chk({busy, done, fail} == 3'b000, "R1", "reset flags", {busy, done, fail}, 0);
  endtask

  task automatic t_hold(input logic [31:0] idv);
    repeat (50) @(negedge clk);
    chk(done == 1'b1 && id == idv && sclk == 1'b0, "R8", "result held while idle",
        id, idv);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    run_read(32'h3C5A_96E1, 1'b0, 1'b0, "basic");
    t_hold(32'h3C5A_96E1);
    run_read(32'h8000_0001, 1'b0, 1'b0, "end bits");
    run_read(32'h7FFF_FFFE, 1'b0, 1'b0, "inner ones");
    run_read(32'h2468_ACE1, 1'b1, 1'b0, "broken chain");
    run_read(32'h0F0F_0F0F, 1'b0, 1'b0, "recover");
    run_read(32'hA5C3_1E79, 1'b0, 1'b1, "start while busy");
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    failed++;
    $display("FAIL R2 watchdog: actual=timeout expected=completion");
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule